// File: doc/BRIEF.md
# Byte Adder with Carry Chaining and Selectable Saturation

This block adds two operand words, 8 bits wide by default, in one registered step. A select input decides whether the incoming carry takes part in the sum. With the carry left out, the block performs a plain add. With the carry included, it continues a wider sum. Software or a test sequence can build additions of any width this way. It adds the lowest words first with a plain add, then each higher word with carry included, feeding in the carry flag from the previous step.

Three result policies are available. Wrap keeps the sum modulo 2^W. Unsigned saturation pins an out-of-range result at the all-ones value. Signed saturation pins it at the largest positive or most negative two's-complement value. Whatever the policy, the carry and signed-overflow flags always describe the raw wrapped addition. The zero flag describes the word actually delivered.

Top module: `adc_sat_adder`

## Requirements
- R1: When `use_cin_i` is 0, `cin_i` has no effect on the result or flags; the sum is `a_i + b_i` as though the carry were clear.
- R2: When `use_cin_i` is 1, `cin_i` is added into the sum as a third term of weight one.
- R3: `carry_o` is 1 exactly when the unsigned sum (including any used carry-in) exceeds 2^W-1; in wrap mode `sum_o` is that sum modulo 2^W (e.g. 200 + 100 gives 44 with carry set).
- R4: `ovf_o` is 1 exactly when the two's-complement sum (including any used carry-in) lies outside -2^(W-1) .. 2^(W-1)-1 (e.g. 100 + 100 gives 0xC8 with overflow set).
- R5: With `mode_i` = 1 (unsigned saturate), a sum that sets the carry delivers all ones (0xFF); otherwise the wrapped sum.
- R6: With `mode_i` = 2 (signed saturate), an overflowing sum delivers 0x7F when `a_i` is non-negative and 0x80 when `a_i` is negative; otherwise the wrapped sum.
- R7: `zero_o` is 1 exactly when the delivered `sum_o` is zero, after any clamping.
- R8: `carry_o` and `ovf_o` report the raw wrapped addition in every mode, including when the result is clamped.
- R9: `mode_i` = 0 and the reserved code `mode_i` = 3 both select wrap behaviour.
- R10: Inputs sampled at a rising clock edge give their result and flags on the outputs right after that edge; while `rst_n` is low the outputs hold `sum_o` = 0, `carry_o` = 0, `ovf_o` = 0, `zero_o` = 1.
- R11: Adding the low bytes with `use_cin_i` = 0 and then the high bytes with `use_cin_i` = 1 and `cin_i` set to the low step's `carry_o` yields the correct 16-bit sum and its carry out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into the addition |
| use_cin_i | input | 1 | 1 = add with carry, 0 = plain add |
| mode_i | input | 2 | 0 wrap, 1 unsigned saturate, 2 signed saturate, 3 wrap |
| sum_o | output | WIDTH | Registered result word |
| carry_o | output | 1 | Raw unsigned carry out |
| ovf_o | output | 1 | Raw signed overflow |
| zero_o | output | 1 | Delivered result is zero |

## Verification
Each operand set presented before a rising edge produces its result word and all three flags directly after that edge. So every outcome is due exactly one cycle after its stimulus. The bench drives on falling edges and queues one expected item per stimulus. Just after each rising edge, it takes exactly one item from the queue and compares it with the outputs. In this way each comparison lines up with the cycle that captured its inputs. Reset values are sampled while reset is held, both at start-up and in the middle of the run.

// File: rtl/adc_sat_pkg.sv
package adc_sat_pkg;

  typedef enum logic [1:0] {
    POL_WRAP = 2'd0,
    POL_USAT = 2'd1,
    POL_SSAT = 2'd2,
    POL_RSVD = 2'd3
  } sat_policy_e;

endpackage

// File: rtl/adc_sat_raw.sv
module adc_sat_raw #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             cin_eff,
  output logic [WIDTH-1:0] raw_sum,
  output logic             raw_carry,
  output logic             raw_ovf
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] ext_sum;

  always_comb begin
    ext_sum   = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, cin_eff};
    raw_sum   = ext_sum[MSB:0];
    raw_carry = ext_sum[WIDTH];
    raw_ovf   = (op_a[MSB] == op_b[MSB]) && (raw_sum[MSB] != op_a[MSB]);
  end

endmodule

// File: rtl/adc_sat_clamp.sv
module adc_sat_clamp
  import adc_sat_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] raw_sum,
  input  logic             raw_carry,
  input  logic             raw_ovf,
  input  logic             ops_neg,
  input  sat_policy_e      policy,
  output logic [WIDTH-1:0] final_sum
);

  localparam logic [WIDTH-1:0] UMAX = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] SMAX = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] SMIN = {1'b1, {(WIDTH-1){1'b0}}};

  always_comb begin
    case (policy)
      POL_USAT: final_sum = raw_carry ? UMAX : raw_sum;
      POL_SSAT: final_sum = raw_ovf ? (ops_neg ? SMIN : SMAX) : raw_sum;
      default:  final_sum = raw_sum;
    endcase
  end

endmodule

// File: rtl/adc_sat_adder.sv
module adc_sat_adder
  import adc_sat_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  input  logic             use_cin_i,
  input  logic [1:0]       mode_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o,
  output logic             ovf_o,
  output logic             zero_o
);

  logic             cin_eff;
  logic [WIDTH-1:0] raw_sum;
  logic             raw_carry;
  logic             raw_ovf;
  logic [WIDTH-1:0] final_sum;
  sat_policy_e      policy;

  logic [WIDTH-1:0] sum_d,   sum_q;
  logic             carry_d, carry_q;
  logic             ovf_d,   ovf_q;
  logic             zero_d,  zero_q;

  assign cin_eff = use_cin_i & cin_i;
  assign policy  = sat_policy_e'(mode_i);

  adc_sat_raw #(.WIDTH(WIDTH)) u_raw (
    .op_a      (a_i),
    .op_b      (b_i),
    .cin_eff   (cin_eff),
    .raw_sum   (raw_sum),
    .raw_carry (raw_carry),
    .raw_ovf   (raw_ovf)
  );

  adc_sat_clamp #(.WIDTH(WIDTH)) u_clamp (
    .raw_sum   (raw_sum),
    .raw_carry (raw_carry),
    .raw_ovf   (raw_ovf),
    .ops_neg   (a_i[WIDTH-1]),
    .policy    (policy),
    .final_sum (final_sum)
  );

  always_comb begin
    sum_d   = final_sum;
    carry_d = raw_carry;
    ovf_d   = raw_ovf;
    zero_d  = (final_sum == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q   <= '0;
      carry_q <= 1'b0;
      ovf_q   <= 1'b0;
      zero_q  <= 1'b1;
    end else begin
      sum_q   <= sum_d;
      carry_q <= carry_d;
      ovf_q   <= ovf_d;
      zero_q  <= zero_d;
    end
  end

  assign sum_o   = sum_q;
  assign carry_o = carry_q;
  assign ovf_o   = ovf_q;
  assign zero_o  = zero_q;

endmodule

// File: rtl/adc_sat_adder_chk.sv
module adc_sat_adder_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             cin_i,
  input logic             use_cin_i,
  input logic [1:0]       mode_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             carry_o,
  input logic             ovf_o,
  input logic             zero_o
);

  localparam logic [WIDTH-1:0] UMAX = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] SMAX = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] SMIN = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] plain_sum;
  logic [WIDTH:0]   uwide;
  logic [WIDTH:0]   swide;
  logic             s_out;

  always_comb begin
    plain_sum = a_i + b_i;
    uwide = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, (use_cin_i & cin_i)};
    swide = {a_i[WIDTH-1], a_i} + {b_i[WIDTH-1], b_i}
          + {{WIDTH{1'b0}}, (use_cin_i & cin_i)};
    s_out = swide[WIDTH] ^ swide[WIDTH-1];
  end

  p_plain_add_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_cin_i && (mode_i == 2'd0)) |=> (sum_o == $past(plain_sum)));

  p_carry_raw_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (carry_o == $past(uwide[WIDTH])));

  p_ovf_raw_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ovf_o == $past(s_out)));

  p_usat_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == 2'd1) && uwide[WIDTH]) |=> (sum_o == UMAX));

  p_ssat_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == 2'd2) && s_out && !a_i[WIDTH-1]) |=> (sum_o == SMAX));

  p_ssat_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == 2'd2) && s_out && a_i[WIDTH-1]) |=> (sum_o == SMIN));

  p_zero_final_r7: assert property (@(posedge clk) disable iff (!rst_n)
    zero_o == (sum_o == '0));

  p_rsvd_wraps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd3) |=> (sum_o == $past(uwide[WIDTH-1:0])));

endmodule

bind adc_sat_adder adc_sat_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .a_i       (a_i),
  .b_i       (b_i),
  .cin_i     (cin_i),
  .use_cin_i (use_cin_i),
  .mode_i    (mode_i),
  .sum_o     (sum_o),
  .carry_o   (carry_o),
  .ovf_o     (ovf_o),
  .zero_o    (zero_o)
);

// File: tb/adc_sat_adder_bench.sv
module adc_sat_adder_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 5000;

  logic       clk;
  logic       rst_n;
  logic [7:0] a_i, b_i;
  logic       cin_i, use_cin_i;
  logic [1:0] mode_i;
  logic [7:0] sum_o;
  logic       carry_o, ovf_o, zero_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  logic [10:0] exp_q[$];
  string       tag_q[$];

  adc_sat_adder u_adc_sat_adder (
    .clk(clk), .rst_n(rst_n), .a_i(a_i), .b_i(b_i), .cin_i(cin_i),
    .use_cin_i(use_cin_i), .mode_i(mode_i), .sum_o(sum_o),
    .carry_o(carry_o), .ovf_o(ovf_o), .zero_o(zero_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic check_out(string tag, logic [10:0] exp_v);
    logic [10:0] act;
    act = {sum_o, carry_o, ovf_o, zero_o};
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual sum=%02h c=%0b v=%0b z=%0b expected sum=%02h c=%0b v=%0b z=%0b",
               tag, act[10:3], act[2], act[1], act[0],
               exp_v[10:3], exp_v[2], exp_v[1], exp_v[0]);
    end
  endtask

  // Expected outcome computed from the requirements
  function automatic logic [10:0] model(logic [7:0] a, logic [7:0] b,
                                        logic ci, logic use_ci, logic [1:0] md);
    int u, s, c;
    logic [7:0] res;
    logic cy, ov;
    c   = (use_ci && ci) ? 1 : 0;
    u   = int'(a) + int'(b) + c;
    s   = int'($signed(a)) + int'($signed(b)) + c;
    cy  = (u > 255);
    ov  = (s > 127) || (s < -128);
    res = u[7:0];
    if (md == 2'd1 && cy) res = 8'hFF;
    if (md == 2'd2 && ov) res = (s > 127) ? 8'h7F : 8'h80;
    return {res, cy, ov, (res == 8'h00)};
  endfunction

  task automatic drive(string tag, logic [7:0] a, logic [7:0] b,
                       logic ci, logic use_ci, logic [1:0] md);
    @(negedge clk);
    a_i = a; b_i = b; cin_i = ci; use_cin_i = use_ci; mode_i = md;
    exp_q.push_back(model(a, b, ci, use_ci, md));
    tag_q.push_back(tag);
  endtask

  task automatic drive_exp(string tag, logic [7:0] a, logic [7:0] b,
                           logic ci, logic use_ci, logic [1:0] md, logic [10:0] e);
    @(negedge clk);
    a_i = a; b_i = b; cin_i = ci; use_cin_i = use_ci; mode_i = md;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: one result due right after each rising edge following a stimulus
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && exp_q.size() != 0) begin
        check_out(tag_q.pop_front(), exp_q.pop_front());
      end
    end
  end

  // Watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WD_LIMIT && !done) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual cycles=%0d expected below %0d", cycles, WD_LIMIT);
        finish_run();
      end
    end
  end

  initial begin
    logic [31:0] lfsr;
    logic [15:0] wa, wb;
    logic [16:0] wsum;
    rst_n = 1'b0;
    a_i = 8'h00; b_i = 8'h00; cin_i = 1'b0; use_cin_i = 1'b0; mode_i = 2'd0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check_out("R10 reset", {8'h00, 1'b0, 1'b0, 1'b1});
    a_i = 8'hC8; b_i = 8'h64;
    @(negedge clk);
    check_out("R10 reset holds", {8'h00, 1'b0, 1'b0, 1'b1});
    rst_n = 1'b1;

    // R1: plain add ignores carry-in
    drive_exp("R1 plain ignores cin", 8'd200, 8'd100, 1'b1, 1'b0, 2'd0, {8'd44, 1'b1, 1'b0, 1'b0});
    drive_exp("R1 small plain",       8'h10, 8'h20, 1'b1, 1'b0, 2'd0, {8'h30, 1'b0, 1'b0, 1'b0});
    // R2: add with carry
    drive_exp("R2 adc",               8'h10, 8'h20, 1'b1, 1'b1, 2'd0, {8'h31, 1'b0, 1'b0, 1'b0});
    drive_exp("R2 adc to zero",       8'hFF, 8'h00, 1'b1, 1'b1, 2'd0, {8'h00, 1'b1, 1'b0, 1'b1});
    // R3: carry and wrap
    drive_exp("R3 wrap carry",        8'd200, 8'd100, 1'b0, 1'b0, 2'd0, {8'd44, 1'b1, 1'b0, 1'b0});
    // R4: signed overflow
    drive_exp("R4 pos ovf",           8'd100, 8'd100, 1'b0, 1'b0, 2'd0, {8'hC8, 1'b0, 1'b1, 1'b0});
    drive_exp("R4 neg ovf",           8'h80, 8'h80, 1'b0, 1'b0, 2'd0, {8'h00, 1'b1, 1'b1, 1'b1});
    drive_exp("R4 adc ovf",           8'h7F, 8'h00, 1'b1, 1'b1, 2'd0, {8'h80, 1'b0, 1'b1, 1'b0});
    // R5: unsigned saturation
    drive_exp("R5 usat clamp",        8'd200, 8'd100, 1'b0, 1'b0, 2'd1, {8'hFF, 1'b1, 1'b0, 1'b0});
    drive_exp("R5 usat pass",         8'd10, 8'd20, 1'b0, 1'b0, 2'd1, {8'd30, 1'b0, 1'b0, 1'b0});
    // R6: signed saturation
    drive_exp("R6 ssat high",         8'd100, 8'd100, 1'b0, 1'b0, 2'd2, {8'h7F, 1'b0, 1'b1, 1'b0});
    drive_exp("R6 ssat low",          8'h80, 8'hFF, 1'b0, 1'b0, 2'd2, {8'h80, 1'b1, 1'b1, 1'b0});
    drive_exp("R6 ssat adc high",     8'h7F, 8'h00, 1'b1, 1'b1, 2'd2, {8'h7F, 1'b0, 1'b1, 1'b0});
    drive_exp("R6 ssat no ovf",       8'hFF, 8'h01, 1'b0, 1'b0, 2'd2, {8'h00, 1'b1, 1'b0, 1'b1});
    // R7: zero flag after clamping
    drive_exp("R7 zero after clamp",  8'hFF, 8'h01, 1'b0, 1'b0, 2'd1, {8'hFF, 1'b1, 1'b0, 1'b0});
    // R8: raw flags while clamped
    drive_exp("R8 flags raw usat",    8'hF0, 8'hF0, 1'b0, 1'b0, 2'd1, {8'hFF, 1'b1, 1'b0, 1'b0});
    drive_exp("R8 flags raw ssat",    8'h90, 8'h90, 1'b0, 1'b0, 2'd2, {8'h80, 1'b1, 1'b1, 1'b0});
    // R9: reserved code wraps
    drive_exp("R9 reserved wraps",    8'd200, 8'd100, 1'b0, 1'b0, 2'd3, {8'd44, 1'b1, 1'b0, 1'b0});
    drive_exp("R9 reserved no clamp", 8'd100, 8'd100, 1'b0, 1'b0, 2'd3, {8'hC8, 1'b0, 1'b1, 1'b0});

    // R11: 16-bit chains, expected bytes taken from the wide sum
    for (int k = 0; k < 3; k++) begin
      wa = (k == 0) ? 16'h12FF : (k == 1) ? 16'hFFFF : 16'h8001;
      wb = (k == 0) ? 16'h0101 : (k == 1) ? 16'h0001 : 16'h7FFF;
      wsum = {1'b0, wa} + {1'b0, wb};
      drive("R11 chain low", wa[7:0], wb[7:0], 1'b1, 1'b0, 2'd0);
      drive_exp("R11 chain high", wa[15:8], wb[15:8],
                (({1'b0, wa[7:0]} + {1'b0, wb[7:0]}) > 9'd255), 1'b1, 2'd0,
                {wsum[15:8], wsum[16],
                 ((wa[15] == wb[15]) && (wsum[15] != wa[15])),
                 (wsum[15:8] == 8'h00)});
    end

    // R8: broad sweep over all modes against the model
    lfsr = 32'h1ACE5EED;
    for (int n = 0; n < 300; n++) begin
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      drive("R8 sweep", lfsr[31:24], lfsr[23:16], lfsr[5], lfsr[9], lfsr[13:12]);
    end

    // R10: reset in mid-run
    drain();
    rst_n = 1'b0;
    #1;
    check_out("R10 midrun reset", {8'h00, 1'b0, 1'b0, 1'b1});
    @(negedge clk);
    rst_n = 1'b1;
    drive_exp("R10 after reset", 8'h01, 8'h02, 1'b0, 1'b0, 2'd0, {8'h03, 1'b0, 1'b0, 1'b0});
    drain();
    done = 1;
    finish_run();
  end

endmodule